// File: doc/BRIEF.md
# Shift-Add Multiplication Sequencer

This block is a hardwired finite-state controller for a general register-file datapath: an ALU, a register file and a small data memory. It steps that datapath through an unsigned shift-and-add multiplication. It clears a base register and loads the multiplicand and the multiplier from memory words 0 and 1. It then clears the product register and loops. On each pass it isolates the low bit of the multiplier, shifts the multiplier right, adds the multiplicand into the product only when that bit was one, and shifts the multiplicand left. The loop runs again while the multiplier is nonzero. At the end the product is written to memory word 2.

Each state drives one complete control word: destination, two source selects, an immediate and its select, the ALU function, the memory-to-register select, the register write enable and the memory write enable. The sequencer takes the current values of the bit register (R4) and the multiplier register (R2) and feeds them to its own zero detectors, so its branches do not depend on the ALU flags. A multiplier bit of zero jumps past the add state. A zero multiplier ends the loop at once, so the pass count depends on the position of the multiplier's highest set bit.

All pins are plain control and status. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure to obey.

Top module: `mulseq_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, the sequencer is idle. In the idle state every control field is 0 (both write enables low) and done is 0.
- R2: In the idle state the sequencer stays idle while start is 0. If start is 1 at a clock edge, it runs the first setup step in the next cycle.
- R3: The four setup steps occupy one cycle each and run in this order. ALU function codes are ADD=0, SUB=1, AND=2, SHR=3, SHL=4, and any field not named is 0. (a) R0 <= R0-R0: dst 0, srca 0, srcb 0, SUB, reg_we. (b) R1 <= M[R0+0]: dst 1, srca 0, use_imm, imm 0, ADD, mem_to_reg, reg_we. (c) R2 <= M[R0+1]: dst 2, srca 0, use_imm, imm 1, ADD, mem_to_reg, reg_we. (d) R3 <= R3-R3: dst 3, srca 3, srcb 3, SUB, reg_we.
- R4: After setup and after each loop return, the bit step R4 <= R2&1 (dst 4, srca 2, use_imm, imm 1, AND, reg_we) is followed by the step R2 <= R2>>1 (dst 2, srca 2, SHR, reg_we).
- R5: After the R2 shift step, the next step is the add step if bit_reg is nonzero and the R1 shift step if bit_reg is zero.
- R6: The add step is R3 <= R3+R1 (dst 3, srca 3, srcb 1, ADD, reg_we). It is always followed by the step R1 <= R1<<1 (dst 1, srca 1, SHL, reg_we).
- R7: After the R1 shift step, the next step is the bit step if mplier_reg is nonzero and the store step if it is zero.
- R8: The store step M[R0+2] <= R3 drives srca 0, srcb 3, use_imm, imm 2, ADD, mem_we=1 and reg_we=0.
- R9: The cycle after the store step, the sequencer is idle with done=1. Done lasts exactly one cycle.
- R10: mem_we is 1 only in the store step. reg_we is 0 only in the idle state and in the store step.
- R11: start has no effect outside the idle state.
- R12: Driving a matching datapath, a run leaves (A*B) mod 2^DATA_W in memory word 2. For example, 5 x 3 gives 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication when idle |
| bit_reg | input | DATA_W | Current value of the bit register R4 |
| mplier_reg | input | DATA_W | Current value of the multiplier register R2 |
| dst_sel | output | 3 | Destination register index |
| srca_sel | output | 3 | Source A register index |
| srcb_sel | output | 3 | Source B register index |
| use_imm | output | 1 | Take operand B from imm_val |
| imm_val | output | IMM_W | Immediate operand |
| alu_fn | output | 3 | ALU function code |
| mem_to_reg | output | 1 | Write memory read data instead of ALU result |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Memory write enable |
| done | output | 1 | One-cycle pulse after the product is stored |

## Verification
The control word depends only on the current state, so a wrong state shows at the ports in the cycle it is entered: a step the sequencer should not take, a missing add, or an extra loop pass changes dst_sel or alu_fn that same cycle. A wrong branch decision therefore shows one cycle after the deciding edge. A corrupted datapath result shows later, as a different loop length or a wrong value in memory word 2. The bench compares every field against a behavioural model on every clock. It also runs products whose multipliers are zero, a power of two and all ones, which covers the earliest exit, the longest run of skipped adds and the longest loop.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
  localparam int RSEL_W = 3;
  localparam int FN_W   = 3;

  localparam logic [RSEL_W-1:0] RG_BASE = 3'd0;
  localparam logic [RSEL_W-1:0] RG_MCND = 3'd1;
  localparam logic [RSEL_W-1:0] RG_MPLR = 3'd2;
  localparam logic [RSEL_W-1:0] RG_PROD = 3'd3;
  localparam logic [RSEL_W-1:0] RG_BIT  = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_CLRB = 4'd1,
    ST_LDA  = 4'd2,
    ST_LDB  = 4'd3,
    ST_CLRP = 4'd4,
    ST_BIT  = 4'd5,
    ST_SHB  = 4'd6,
    ST_ADD  = 4'd7,
    ST_SHA  = 4'd8,
    ST_STO  = 4'd9
  } mstate_e;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_SHR = 3'd3,
    FN_SHL = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic [RSEL_W-1:0] dst;
    logic [RSEL_W-1:0] srca;
    logic [RSEL_W-1:0] srcb;
    logic              use_imm;
    alu_fn_e           fn;
    logic              mem_to_reg;
    logic              reg_we;
    logic              mem_we;
    logic [1:0]        imm_code;
  } cword_t;
endpackage

// File: rtl/mulseq_zdet.sv
module mulseq_zdet #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  assign is_zero = ~|val;
endmodule

// File: rtl/mulseq_next.sv
module mulseq_next
  import mulseq_pkg::*;
(
  input  mstate_e cur,
  input  logic    start,
  input  logic    bit_zero,
  input  logic    mplr_zero,
  output mstate_e nxt
);
  always_comb begin
    nxt = ST_IDLE;
    unique case (cur)
      ST_IDLE: nxt = start ? ST_CLRB : ST_IDLE;
      ST_CLRB: nxt = ST_LDA;
      ST_LDA:  nxt = ST_LDB;
      ST_LDB:  nxt = ST_CLRP;
      ST_CLRP: nxt = ST_BIT;
      ST_BIT:  nxt = ST_SHB;
      ST_SHB:  nxt = bit_zero ? ST_SHA : ST_ADD;
      ST_ADD:  nxt = ST_SHA;
      ST_SHA:  nxt = mplr_zero ? ST_STO : ST_BIT;
      ST_STO:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/mulseq_cword.sv
module mulseq_cword
  import mulseq_pkg::*;
(
  input  mstate_e cur,
  output cword_t  cw
);
  always_comb begin
    cw = '0;
    unique case (cur)
      ST_CLRB: begin
        cw.dst = RG_BASE; cw.srca = RG_BASE; cw.srcb = RG_BASE;
        cw.fn = FN_SUB; cw.reg_we = 1'b1;
      end
      ST_LDA: begin
        cw.dst = RG_MCND; cw.srca = RG_BASE; cw.use_imm = 1'b1;
        cw.imm_code = 2'd0; cw.fn = FN_ADD; cw.mem_to_reg = 1'b1; cw.reg_we = 1'b1;
      end
      ST_LDB: begin
        cw.dst = RG_MPLR; cw.srca = RG_BASE; cw.use_imm = 1'b1;
        cw.imm_code = 2'd1; cw.fn = FN_ADD; cw.mem_to_reg = 1'b1; cw.reg_we = 1'b1;
      end
      ST_CLRP: begin
        cw.dst = RG_PROD; cw.srca = RG_PROD; cw.srcb = RG_PROD;
        cw.fn = FN_SUB; cw.reg_we = 1'b1;
      end
      ST_BIT: begin
        cw.dst = RG_BIT; cw.srca = RG_MPLR; cw.use_imm = 1'b1;
        cw.imm_code = 2'd1; cw.fn = FN_AND; cw.reg_we = 1'b1;
      end
      ST_SHB: begin
        cw.dst = RG_MPLR; cw.srca = RG_MPLR; cw.fn = FN_SHR; cw.reg_we = 1'b1;
      end
      ST_ADD: begin
        cw.dst = RG_PROD; cw.srca = RG_PROD; cw.srcb = RG_MCND;
        cw.fn = FN_ADD; cw.reg_we = 1'b1;
      end
      ST_SHA: begin
        cw.dst = RG_MCND; cw.srca = RG_MCND; cw.fn = FN_SHL; cw.reg_we = 1'b1;
      end
      ST_STO: begin
        cw.srca = RG_BASE; cw.srcb = RG_PROD; cw.use_imm = 1'b1;
        cw.imm_code = 2'd2; cw.fn = FN_ADD; cw.mem_we = 1'b1;
      end
      default: cw = '0;
    endcase
  end
endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
  import mulseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] bit_reg,
  input  logic [DATA_W-1:0] mplier_reg,
  output logic [2:0]        dst_sel,
  output logic [2:0]        srca_sel,
  output logic [2:0]        srcb_sel,
  output logic              use_imm,
  output logic [IMM_W-1:0]  imm_val,
  output logic [2:0]        alu_fn,
  output logic              mem_to_reg,
  output logic              reg_we,
  output logic              mem_we,
  output logic              done
);
  localparam int NWATCH  = 2;
  localparam int IMM_PAD = IMM_W - 2;

  logic [NWATCH-1:0][DATA_W-1:0] watch;
  logic [NWATCH-1:0]             zflag;
  mstate_e                       state_q, state_d;
  cword_t                        cw;

  assign watch[0] = bit_reg;
  assign watch[1] = mplier_reg;

  for (genvar g = 0; g < NWATCH; g++) begin : g_zdet
    mulseq_zdet #(.W(DATA_W)) u_zdet (
      .val     (watch[g]),
      .is_zero (zflag[g])
    );
  end

  mulseq_next u_next (
    .cur       (state_q),
    .start     (start),
    .bit_zero  (zflag[0]),
    .mplr_zero (zflag[1]),
    .nxt       (state_d)
  );

  mulseq_cword u_cword (
    .cur (state_q),
    .cw  (cw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (state_q == ST_STO);
    end
  end

  assign dst_sel    = cw.dst;
  assign srca_sel   = cw.srca;
  assign srcb_sel   = cw.srcb;
  assign use_imm    = cw.use_imm;
  assign imm_val    = {{IMM_PAD{1'b0}}, cw.imm_code};
  assign alu_fn     = cw.fn;
  assign mem_to_reg = cw.mem_to_reg;
  assign reg_we     = cw.reg_we;
  assign mem_we     = cw.mem_we;
endmodule

// File: rtl/mulseq_ctrl_chk.sv
module mulseq_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [DATA_W-1:0] bit_reg,
  input logic [DATA_W-1:0] mplier_reg,
  input logic [2:0]        dst_sel,
  input logic [2:0]        alu_fn,
  input logic              reg_we,
  input logic              mem_we,
  input logic              done
);
  logic idle;
  assign idle = !reg_we && !mem_we;

  assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> (reg_we && alu_fn == 3'd1 && dst_sel == 3'd0));

  assert_zero_bit_skips_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && alu_fn == 3'd3 && bit_reg == '0) |=> (alu_fn == 3'd4));

  assert_set_bit_adds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && alu_fn == 3'd3 && bit_reg != '0) |=> (alu_fn == 3'd0 && dst_sel == 3'd3));

  assert_loop_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && alu_fn == 3'd4 && mplier_reg != '0) |=> (alu_fn == 3'd2 && dst_sel == 3'd4));

  assert_loop_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && alu_fn == 3'd4 && mplier_reg == '0) |=> mem_we);

  assert_store_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !reg_we);

  assert_done_follows_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (done && idle));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mulseq_ctrl mulseq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .bit_reg    (bit_reg),
  .mplier_reg (mplier_reg),
  .dst_sel    (dst_sel),
  .alu_fn     (alu_fn),
  .reg_we     (reg_we),
  .mem_we     (mem_we),
  .done       (done)
);

// File: tb/mulseq_ctrl_bench.sv
module mulseq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] rf [8];
  logic [7:0] mem [4];
  logic [2:0] dst_sel, srca_sel, srcb_sel, alu_fn;
  logic [7:0] imm_val;
  logic       use_imm, mem_to_reg, reg_we, mem_we, done;
  logic [7:0] bit_reg, mplier_reg;

  int total = 0;
  int bad = 0;
  int st = 0;
  int prev_st = 0;
  bit exp_done = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign bit_reg    = rf[4];
  assign mplier_reg = rf[2];

  mulseq_ctrl u_mulseq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_reg(bit_reg), .mplier_reg(mplier_reg),
    .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel), .use_imm(use_imm),
    .imm_val(imm_val), .alu_fn(alu_fn), .mem_to_reg(mem_to_reg), .reg_we(reg_we),
    .mem_we(mem_we), .done(done)
  );

  // {dst,srca,srcb,use_imm,fn,mem_to_reg,reg_we,mem_we,imm}
  function automatic logic [23:0] exp_word(int s);
    case (s)
      1: return {3'd0, 3'd0, 3'd0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 8'd0};
      2: return {3'd1, 3'd0, 3'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 8'd0};
      3: return {3'd2, 3'd0, 3'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 8'd1};
      4: return {3'd3, 3'd3, 3'd3, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 8'd0};
      5: return {3'd4, 3'd2, 3'd0, 1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 8'd1};
      6: return {3'd2, 3'd2, 3'd0, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 8'd0};
      7: return {3'd3, 3'd3, 3'd1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 8'd0};
      8: return {3'd1, 3'd1, 3'd0, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 8'd0};
      9: return {3'd0, 3'd0, 3'd3, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 8'd2};
      default: return 24'd0;
    endcase
  endfunction

  function automatic string req_tag(int s, int p);
    if (p == 6 && (s == 7 || s == 8)) return "R5";
    if (p == 8 && (s == 5 || s == 9)) return "R7";
    case (s)
      0: return "R2";
      1, 2, 3, 4: return "R3";
      5, 6: return "R4";
      7, 8: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic apply_datapath();
    logic [7:0] a, b, res;
    a = rf[srca_sel];
    b = use_imm ? imm_val : rf[srcb_sel];
    case (alu_fn)
      3'd0: res = a + b;
      3'd1: res = a - b;
      3'd2: res = a & b;
      3'd3: res = a >> 1;
      3'd4: res = a << 1;
      default: res = 8'hxx;
    endcase
    if (mem_we) mem[res[1:0]] = rf[srcb_sel];
    if (reg_we) rf[dst_sel] = mem_to_reg ? mem[res[1:0]] : res;
  endtask

  task automatic step(input logic s);
    logic [23:0] w;
    string tag;
    @(negedge clk);
    w = {dst_sel, srca_sel, srcb_sel, use_imm, alu_fn, mem_to_reg, reg_we, mem_we, imm_val};
    tag = req_tag(st, prev_st);
    if (st != 0 && start) tag = {tag, " R11"};
    check(w == exp_word(st), tag, "control word", int'(w), int'(exp_word(st)));
    check(done == exp_done, "R9", "done", int'(done), int'(exp_done));
    check(!(mem_we && (st != 9)) && (reg_we == (st != 0 && st != 9)), "R10",
          "write enables", int'({reg_we, mem_we}), st);
    apply_datapath();
    start = s;
    prev_st = st;
    exp_done = (st == 9);
    case (st)
      0: st = start ? 1 : 0;
      6: st = (rf[4] == 0) ? 8 : 7;
      8: st = (rf[2] != 0) ? 5 : 9;
      9: st = 0;
      default: st = st + 1;
    endcase
  endtask

  task automatic run_mul(input logic [7:0] a, input logic [7:0] b);
    int guard;
    logic [7:0] expp;
    mem[0] = a; mem[1] = b; mem[2] = 8'h5A;
    guard = 0;
    step(1'b1);
    // start stays high through the run (R11: ignored outside idle)
    while (st != 9 && guard < 200) begin
      step(1'b1);
      guard++;
    end
    step(1'b0);
    step(1'b0);
    step(1'b0);
    expp = 8'((int'(a) * int'(b)) & 8'hFF);
    check(mem[2] == expp, "R12", "stored product", int'(mem[2]), int'(expp));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 8'h00;
    for (int i = 0; i < 4; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check({reg_we, mem_we, alu_fn, dst_sel} == 0 && !done, "R1", "reset outputs",
          int'({reg_we, mem_we, alu_fn, dst_sel, done}), 0);
    rst_n = 1'b1;
    step(1'b0);
    for (int i = 0; i < 4; i++) step(1'b0); // R2: idle holds with start low
    run_mul(8'd5, 8'd3);
    run_mul(8'd7, 8'd0);
    run_mul(8'd1, 8'd128);
    run_mul(8'd3, 8'd255);
    run_mul(8'd9, 8'd1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule